// File: doc/BRIEF.md
# SD Card SPI Host Controller

This block is a register-mapped SPI master for driving an SD card in SPI mode. Software controls it through one 32-bit write word and observes it through one 32-bit status word. A write can queue a byte for transmission, acknowledge a received byte, load the serial-clock divider and update three control flags, in any combination. Queued bytes leave through a small transmit FIFO. Each transmitted byte is exchanged full-duplex with the card, and the byte shifted in during that exchange is presented in the status word.

Software handles the card protocol: command framing, CRC, the initialization sequence and data movement. The block adds three helpers for that work. A receive filter holds off capture until the card drives a start bit. A free-running clock mode supplies the power-up clocks with chip select released. The status word also reports card presence, card insertion or removal, and card busy.

Top module: `sdspi_host`

## Requirements
- R1: A write with bit 8 set pushes bits 7:0 into a 4-entry transmit FIFO. A push into a full FIFO is dropped.
- R2: Bits 13 (receive filter), 12 (transceiver enable) and 11 (force clock) are latched only by a write with bit 14 set. On any other write they have no effect.
- R3: A write with bit 10 set loads the clock divider from bits 7:0. Each SCLK half-period lasts divider+1 system clocks. The divider resets to 255, and SCLK stays low whenever it is not running.
- R4: Transfers use SPI mode 0, most significant bit first. MOSI changes only on SCLK falling edges and is high whenever no transfer is in progress.
- R5: When the eighth bit of a byte has been sampled on a rising SCLK edge, the byte appears in status bits 7:0 and byte-available (bit 9) is set.
- R6: A write with bit 9 set clears byte-available and overrun (bit 8). Overrun is set when a byte completes while byte-available is still set and not being acknowledged.
- R7: Status word layout: bits 7:0 hold the received byte, bit 8 overrun, bit 9 available, bit 10 FIFO empty, bit 11 transmitter ready (FIFO not full), bit 12 card busy, bit 13 card changed, bit 14 card detect, and bits 31:15 read 0. After reset the word reads 0x00000C00 with MISO high and the card-detect pin low.
- R8: With the filter enabled, rising-edge samples are discarded until a 0 is sampled directly after a 1. That 0 becomes the first bit of the byte.
- R9: In force-clock mode with the transceiver off, SCLK toggles at the divided rate, chip select stays high, MOSI stays high and no byte is received.
- R10: Chip select (active low) is asserted exactly while the transceiver enable flag is set. Bytes are taken from the FIFO only while it is set.
- R11: Card busy (bit 12) is 1 while MISO is low, after a 2-flop synchronizer.
- R12: The card-detect pin passes a 2-flop synchronizer and is reported as bit 14. Any change of its level sets card changed (bit 13), which a status read (rd_en) clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Command word: byte and strobes |
| rd_en | input | 1 | Status read strobe; clears card changed |
| rd_data | output | 32 | Status word |
| spi_sclk | output | 1 | Serial clock to the card |
| spi_mosi | output | 1 | Serial data to the card |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data from the card |
| card_cd | input | 1 | Card-detect pin |

## Verification
The exchange path is swept over all 256 byte values with MOSI looped back to MISO. A wrong bit order or a wrong sampling edge shows up as a mismatch between the bytes sent, captured by the bench and received. A scripted card stream beginning with several 1 bits separates filtered capture from unfiltered capture, because the two modes yield different bytes from the same stream. The divider is measured in force-clock mode at its reset value and at 0 through 7, which exposes off-by-one errors in the half-period. Filling the FIFO past its depth, and letting two bytes complete with no acknowledge, covers the drop, ready/empty and overrun cases.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
  // command word bit positions (decoded by software, so fixed)
  localparam int CMD_PUSH  = 8;
  localparam int CMD_ACK   = 9;
  localparam int CMD_DIV   = 10;
  localparam int CMD_FORCE = 11;
  localparam int CMD_EN    = 12;
  localparam int CMD_FILT  = 13;
  localparam int CMD_CTRL  = 14;

  // status word, packed from bit 14 down to bit 0
  typedef struct packed {
    logic       present;
    logic       changed;
    logic       busy;
    logic       ready;
    logic       empty;
    logic       avail;
    logic       ovr;
    logic [7:0] data;
  } stat_t;
endpackage

// File: rtl/sdspi_sync.sv
module sdspi_sync #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/sdspi_txfifo.sv
module sdspi_txfifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full); // R1
endmodule

// File: rtl/sdspi_sclkgen.sv
module sdspi_sclkgen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          sclk,
  output logic          rise,
  output logic          fall
);
  logic [DW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt >= div);
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk); // R3
endmodule

// File: rtl/sdspi_host.sv
module sdspi_host #(
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 255
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso,
  input  logic        card_cd
);
  import sdspi_pkg::*;

  localparam int BW = 8;
  localparam int CW = $clog2(BW) + 1;

  logic             en_filt, en_xfer, en_force;
  logic [DIV_W-1:0] div_q;
  logic             busy, done_pend, hunting, prev_bit;
  logic [BW-1:0]    tx_sr, rx_sr, rx_byte;
  logic [CW-1:0]    rx_cnt;
  logic             avail, ovr, changed, cd_prev;
  logic             cd_s, miso_s;
  logic             fifo_empty, fifo_full;
  logic [BW-1:0]    fifo_dout;
  logic             rise, fall, sclk_i;
  stat_t            st;

  wire ctrl_wr = wr_en && wr_data[CMD_CTRL];
  wire div_wr  = wr_en && wr_data[CMD_DIV];
  wire push    = wr_en && wr_data[CMD_PUSH];
  wire ack     = wr_en && wr_data[CMD_ACK];
  wire start   = !busy && en_xfer && !fifo_empty;
  wire bit_take = rise && busy && (!hunting || (prev_bit && !spi_miso));
  wire rx_done  = bit_take && (rx_cnt == CW'(BW - 1));

  sdspi_sync #(.W(2), .RST_VAL(2'b01)) i_sync (
    .clk(clk), .rst(rst), .d({card_cd, spi_miso}), .q({cd_s, miso_s}));

  sdspi_txfifo #(.W(BW), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .push(push), .din(wr_data[BW-1:0]),
    .pop(start), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full));

  sdspi_sclkgen #(.DW(DIV_W)) i_clk (
    .clk(clk), .rst(rst), .run(busy || en_force), .div(div_q),
    .sclk(sclk_i), .rise(rise), .fall(fall));

  // control flags and divider
  always_ff @(posedge clk) begin
    if (rst) begin
      {en_filt, en_xfer, en_force} <= 3'b000;
      div_q <= DIV_W'(DIV_RESET);
    end else begin
      if (ctrl_wr) {en_filt, en_xfer, en_force} <= wr_data[CMD_FILT:CMD_FORCE];
      if (div_wr)  div_q <= wr_data[DIV_W-1:0];
    end
  end

  // shift engine
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done_pend <= 1'b0;
      hunting   <= 1'b0;
      prev_bit  <= 1'b0;
      tx_sr     <= '1;
      rx_sr     <= '0;
      rx_cnt    <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      done_pend <= 1'b0;
      hunting   <= en_filt;
      prev_bit  <= 1'b0;
      tx_sr     <= fifo_dout;
      rx_cnt    <= '0;
    end else if (busy) begin
      if (rise && hunting) prev_bit <= spi_miso;
      if (bit_take) begin
        rx_sr   <= {rx_sr[BW-2:0], spi_miso};
        rx_cnt  <= rx_cnt + 1'b1;
        hunting <= 1'b0;
        if (rx_done) done_pend <= 1'b1;
      end
      if (fall) begin
        tx_sr <= {tx_sr[BW-2:0], 1'b1};
        if (done_pend) busy <= 1'b0;
      end
    end
  end

  // receive status and card change
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      avail   <= 1'b0;
      ovr     <= 1'b0;
      changed <= 1'b0;
      cd_prev <= 1'b0;
    end else begin
      if (ack) begin
        avail <= 1'b0;
        ovr   <= 1'b0;
      end
      if (rx_done) begin
        rx_byte <= {rx_sr[BW-2:0], spi_miso};
        avail   <= 1'b1;
        if (avail && !ack) ovr <= 1'b1;
      end
      cd_prev <= cd_s;
      if (cd_s != cd_prev) changed <= 1'b1;
      else if (rd_en)      changed <= 1'b0;
    end
  end

  always_comb begin
    st.present = cd_s;
    st.changed = changed;
    st.busy    = !miso_s;
    st.ready   = !fifo_full;
    st.empty   = fifo_empty;
    st.avail   = avail;
    st.ovr     = ovr;
    st.data    = rx_byte;
  end

  assign rd_data  = {{(32 - $bits(stat_t)){1'b0}}, st};
  assign spi_sclk = sclk_i;
  assign spi_mosi = tx_sr[BW-1];
  assign spi_cs_n = !en_xfer;

  AST_MOSI_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_mosi); // R4
  AST_AVAIL_SET: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> avail); // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_done && avail && !ack) |=> ovr); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ack && !rx_done) |=> (!avail && !ovr)); // R6
  AST_CHG_SET: assert property (@(posedge clk) disable iff (rst)
    (cd_s != cd_prev) |=> changed); // R12
  AST_FORCE_NO_CS: assert property (@(posedge clk) disable iff (rst)
    (en_force && !en_xfer) |-> spi_cs_n); // R9
endmodule

// File: tb/test_sdspi_host.sv
module test_sdspi_host;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        spi_sclk, spi_mosi, spi_cs_n, spi_miso;
  logic        card_cd = 1'b0;
  logic        loop = 1'b0;
  logic [23:0] card_sr = '1;
  logic        card_load = 1'b0;
  logic [23:0] card_val = '1;
  logic [7:0]  mos_sr = '0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign spi_miso = loop ? spi_mosi : card_sr[23];

  always @(negedge spi_sclk or posedge card_load) begin
    if (card_load) card_sr <= card_val;
    else           card_sr <= {card_sr[22:0], 1'b1};
  end
  always @(posedge spi_sclk) mos_sr <= {mos_sr[6:0], spi_mosi};

  sdspi_host i_sdspi_host (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .card_cd(card_cd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); d = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_avail();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rd_data[9]) break;
    end
  endtask

  task automatic set_card(input logic [23:0] v);
    @(negedge clk); card_val = v; card_load = 1'b1;
    @(negedge clk); card_load = 1'b0;
  endtask

  task automatic half_period(output int n);
    logic s;
    @(negedge clk); s = spi_sclk;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (spi_sclk != s) break;
    end
    s = spi_sclk; n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); n++;
      if (spi_sclk != s) break;
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] st;
    int n;
    bit toggled;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk("R7 reset status", rd_data, 32'h0000_0C00);
    chk("R4 reset pins", {29'b0, spi_sclk, spi_cs_n, spi_mosi}, 32'h3);

    // R3 reset divider, R9 force clock
    wr(32'h4800);
    half_period(n); half_period(n);
    chk("R3 reset half period", n, 256);
    chk("R9 force pins cs_n/mosi/avail", {29'b0, spi_cs_n, spi_mosi, rd_data[9]}, 32'h6);
    for (int d = 0; d < 8; d++) begin
      wr(32'h400 | d);
      half_period(n); half_period(n);
      chk("R3 divider half period", n, d + 1);
    end
    wr(32'h4000);
    wr(32'h400);
    // R2 flags ignored without bit 14
    wr(32'h3800);
    toggled = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (spi_sclk) toggled = 1;
    end
    chk("R2 ignored flags sclk/cs_n", {30'b0, toggled, spi_cs_n}, 32'h1);
    // R10 chip select
    wr(32'h5000);
    chk("R10 cs_n enabled", spi_cs_n, 0);

    // R4 R5 R6 loopback sweep of all byte values
    loop = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(32'h100 | v);
      wait_avail();
      rd(st);
      chk("R5 received byte", {st[9], st[7:0]}, {1'b1, 8'(v)});
      chk("R4 bits on MOSI", mos_sr, v);
      wr(32'h200);
      if (v % 64 == 0) chk("R6 ack clears", rd_data[9:8], 0);
    end

    // R1 R13-style FIFO fill and drop, R10 hold-off
    repeat (40) @(negedge clk);
    wr(32'h4000);
    for (int i = 0; i < 5; i++) wr(32'h1A0 + i);
    chk("R1 full flags empty/ready", rd_data[11:10], 2'b00);
    chk("R10 no transfer while disabled", rd_data[9], 0);
    wr(32'h5000);
    for (int i = 0; i < 4; i++) begin
      wait_avail();
      rd(st);
      chk("R1 FIFO order", st[7:0], 8'hA0 + i);
      wr(32'h200);
    end
    repeat (100) @(negedge clk);
    chk("R1 fifth byte dropped", rd_data[11:9], 3'b110);

    // R6 overrun
    wr(32'h155); wr(32'h1AA);
    repeat (100) @(negedge clk);
    chk("R6 overrun", rd_data[9:0], {2'b11, 8'hAA});
    wr(32'h200);
    chk("R6 ack clears overrun", rd_data[9:8], 0);

    // R8 filter vs unfiltered
    loop = 1'b0;
    wr(32'h4000);
    set_card(24'b1110_1011_0011_1111_1111_1111);
    wr(32'h7000); wr(32'h1FF);
    wait_avail(); rd(st);
    chk("R8 filtered byte", st[7:0], 8'h59);
    wr(32'h200);
    repeat (20) @(negedge clk);
    set_card(24'b1110_1011_0011_1111_1111_1111);
    wr(32'h5000); wr(32'h1FF);
    wait_avail(); rd(st);
    chk("R8 unfiltered byte", st[7:0], 8'hEB);
    wr(32'h200);
    repeat (20) @(negedge clk);

    // R11 card busy
    wr(32'h4000);
    set_card(24'h0);
    repeat (4) @(negedge clk);
    chk("R11 busy while low", rd_data[12], 1);
    set_card(24'hFFFFFF);
    repeat (4) @(negedge clk);
    chk("R11 not busy while high", rd_data[12], 0);

    // R12 card detect and change
    card_cd = 1'b1;
    repeat (4) @(negedge clk);
    rd(st);
    chk("R12 insert detect/changed", st[14:13], 2'b11);
    rd(st);
    chk("R12 changed cleared by read", st[14:13], 2'b10);
    card_cd = 1'b0;
    repeat (4) @(negedge clk);
    rd(st);
    chk("R12 removal", st[14:13], 2'b01);
    chk("R7 upper bits zero", st[31:15], 0);

    finish_run();
  end
endmodule